// File: doc/BRIEF.md
# Multiplexed-Address DRAM Read Sequencer

This block runs read cycles and row refresh on an asynchronous DRAM whose row and column addresses share one set of address pins. A host presents a full word address with a one-cycle read request. The sequencer splits the address into a row part (upper bits) and a column part (lower bits). It drives the active-low row strobe, column strobe and output enable through a fixed order of timed phases. When the access time has elapsed it returns the data word with a one-cycle valid pulse.

A mode input, sampled when the request is accepted, selects where the output enable falls in that order. In early ordering it falls before the column strobe. In late ordering it falls only after the column hold time. A refresh request performs a row-only cycle: the row comes from an internal counter, the column strobe and output enable stay inactive, and the counter steps to the next row afterwards. A minimum strobe-high recovery time separates any two cycles, and the busy output covers the whole operation including that recovery. Every interval is a parameter counted in clock cycles.

Top module: `dram_read_seq`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n, dram_oe_n and dram_we_n are high, and busy and rd_valid are low.
- R2: For a read, dram_a carries rd_addr[ROW_W+COL_W-1:COL_W] (the row) when dram_ras_n falls, and rd_addr[COL_W-1:0] (the column) when dram_cas_n falls.
- R3: The row stays on dram_a for at least T_RSU cycles before dram_ras_n falls. In a read it stays for exactly T_RH cycles after the fall, and then the column replaces it.
- R4: The column stays on dram_a for at least T_CSU cycles before dram_cas_n falls. dram_cas_n is low only while dram_ras_n is low.
- R5: With late_mode=0 at acceptance (early ordering), dram_oe_n is already low in the cycle in which dram_cas_n falls.
- R6: With late_mode=1 at acceptance (late ordering), dram_oe_n is high when dram_cas_n falls, and it falls exactly T_CH cycles after dram_cas_n.
- R7: rd_valid is a one-cycle pulse that carries the dram_dq word present at the end of the access phase. It comes T_ACC cycles after output enable falls in late ordering, and T_CH+T_ACC cycles after dram_cas_n falls in early ordering. In that cycle dram_ras_n, dram_cas_n and dram_oe_n are all high again.
- R8: A refresh presents the internal row counter on dram_a at the dram_ras_n fall and keeps dram_ras_n low for T_RH+T_ACC cycles, while dram_cas_n and dram_oe_n stay high. The counter then steps by one and wraps from N_ROWS-1 to 0. It starts at 0.
- R9: busy rises in the cycle after a request is accepted. It falls exactly T_PRE cycles after dram_ras_n rises. dram_ras_n stays high for at least T_PRE cycles between two cycles.
- R10: When rd_req and rfsh_req arrive in the same idle cycle, the refresh is performed and that read is discarded.
- R11: A rfsh_req raised during a read is held pending. The read completes unchanged, and the refresh follows on its own.
- R12: rd_req while busy is high is ignored: it yields no extra access and no extra rd_valid.
- R13: dram_we_n is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, taken only when idle |
| rd_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| late_mode | input | 1 | 1 selects late output-enable ordering |
| rfsh_req | input | 1 | Refresh request pulse |
| busy | output | 1 | Operation or recovery in progress |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Captured read word |
| dram_a | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_we_n | output | 1 | Write enable, held high |
| dram_dq | input | DATA_W | Data from the memory |

## Verification
A read and a refresh can be requested in the same cycle. This is provoked in two ways: both requests are raised together while the block is idle, and a refresh pulse is raised in the middle of a read. In the first case the bench expects a row-only cycle at the counter's row with no data strobe and no later read. In the second case it expects the read's strobe timing and data to be untouched, followed by a refresh cycle that no further request started. A bench-side memory model latches the row and column on the strobe edges and judges every phase length and data word against values computed from the parameters.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RSU, ST_RHLD, ST_CSU, ST_CHLD, ST_ACC, ST_RACT, ST_PRE
   } seq_st_e;

   typedef enum logic [1:0] {AS_NONE, AS_ROW, AS_COL} asel_e;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic oe_n;
   } strobe_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_seq_amux.sv
module dram_seq_amux
   import dram_seq_pkg::*;
#(
   parameter int ROW_W = 9,
   parameter int COL_W = 9,
   parameter int PIN_W = 9
) (
   input  asel_e              sel,
   input  logic [ROW_W-1:0]   row,
   input  logic [COL_W-1:0]   col,
   output logic [PIN_W-1:0]   pins
);

   logic [PIN_W-1:0] row_x;
   logic [PIN_W-1:0] col_x;

   generate
      if (ROW_W == PIN_W) begin : g_row_full
         assign row_x = row;
      end else begin : g_row_pad
         assign row_x = {{(PIN_W-ROW_W){1'b0}}, row};
      end
      if (COL_W == PIN_W) begin : g_col_full
         assign col_x = col;
      end else begin : g_col_pad
         assign col_x = {{(PIN_W-COL_W){1'b0}}, col};
      end
   endgenerate

   always_comb begin
      case (sel)
         AS_ROW:  pins = row_x;
         AS_COL:  pins = col_x;
         default: pins = '0;
      endcase
   end

endmodule

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   AST_TMR_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && done) |=> done); // R3

endmodule

// File: rtl/dram_seq_rfsh.sv
module dram_seq_rfsh #(
   parameter int ROW_W  = 9,
   parameter int N_ROWS = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             take,
   input  logic             adv,
   output logic             pend,
   output logic [ROW_W-1:0] row
);

   localparam logic [ROW_W-1:0] LAST = ROW_W'(N_ROWS - 1);

   logic             pend_q;
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_nx;

   generate
      if ((N_ROWS < 2) || (N_ROWS > (1 << ROW_W))) begin : g_bad_rows
         $error("dram_seq_rfsh: N_ROWS must lie in 2..2**ROW_W");
      end
      if (N_ROWS == (1 << ROW_W)) begin : g_wrap_free
         assign row_nx = row_q + 1'b1;
      end else begin : g_wrap_cmp
         assign row_nx = (row_q == LAST) ? '0 : row_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         row_q  <= '0;
      end else begin
         pend_q <= (pend_q | req) & ~take;
         if (adv) row_q <= row_nx;
      end
   end

   assign pend = pend_q | req;
   assign row  = row_q;

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (($past(row_q) == LAST) ? (row_q == '0) : (row_q == $past(row_q) + 1'b1))); // R8
   AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !take) |=> pend); // R11

endmodule

// File: rtl/dram_read_seq.sv
module dram_read_seq
   import dram_seq_pkg::*;
#(
   parameter int ROW_W  = 9,
   parameter int COL_W  = 9,
   parameter int DATA_W = 8,
   parameter int N_ROWS = 2 ** ROW_W,
   parameter int T_RSU  = 1,
   parameter int T_RH   = 1,
   parameter int T_CSU  = 1,
   parameter int T_CH   = 1,
   parameter int T_ACC  = 2,
   parameter int T_PRE  = 2,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              late_mode,
   input  logic              rfsh_req,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [PIN_W-1:0]  dram_a,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_oe_n,
   output logic              dram_we_n,
   input  logic [DATA_W-1:0] dram_dq
);

   localparam int MAXD = max_of(max_of(max_of(T_RSU, T_RH), max_of(T_CSU, T_CH)),
                                max_of(T_ACC, T_PRE));
   localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

   generate
      if ((T_RSU < 1) || (T_RH < 1) || (T_CSU < 1) || (T_CH < 1) ||
          (T_ACC < 1) || (T_PRE < 1)) begin : g_bad_time
         $error("dram_read_seq: every interval must be at least one cycle");
      end
      if ((ROW_W < 1) || (COL_W < 1) || (DATA_W < 1)) begin : g_bad_width
         $error("dram_read_seq: widths must be positive");
      end
   endgenerate

   seq_st_e          st_q, st_n;
   logic             rf_q, rf_n;
   logic             late_q, late_n;
   logic [ROW_W-1:0] row_q, row_n;
   logic [COL_W-1:0] col_q, col_n;
   logic             tmr_load, tmr_done;
   logic [CW-1:0]    tmr_val;
   logic             rf_pend, rf_take, rf_adv;
   logic [ROW_W-1:0] rf_row;
   logic             capture;
   strobe_t          stb_n;
   asel_e            asel_n;
   logic [PIN_W-1:0] pins_n;

   function automatic int dur_of(input seq_st_e s);
      case (s)
         ST_RSU:  return T_RSU;
         ST_RHLD: return T_RH;
         ST_CSU:  return T_CSU;
         ST_CHLD: return T_CH;
         ST_ACC:  return T_ACC;
         ST_RACT: return T_ACC;
         ST_PRE:  return T_PRE;
         default: return 1;
      endcase
   endfunction

   function automatic strobe_t decode(input seq_st_e s, input logic late);
      strobe_t o;
      o.ras_n = !(s inside {ST_RHLD, ST_CSU, ST_CHLD, ST_ACC, ST_RACT});
      o.cas_n = !(s inside {ST_CHLD, ST_ACC});
      o.oe_n  = !((s == ST_ACC) || (!late && (s inside {ST_CSU, ST_CHLD})));
      return o;
   endfunction

   always_comb begin
      st_n    = st_q;
      rf_n    = rf_q;
      late_n  = late_q;
      row_n   = row_q;
      col_n   = col_q;
      rf_take = 1'b0;
      rf_adv  = 1'b0;
      capture = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (rf_pend) begin
               rf_take = 1'b1;
               rf_n    = 1'b1;
               row_n   = rf_row;
               st_n    = ST_RSU;
            end else if (rd_req) begin
               rf_n    = 1'b0;
               late_n  = late_mode;
               row_n   = rd_addr[ADDR_W-1:COL_W];
               col_n   = rd_addr[COL_W-1:0];
               st_n    = ST_RSU;
            end
         end
         ST_RSU:  if (tmr_done) st_n = ST_RHLD;
         ST_RHLD: if (tmr_done) st_n = rf_q ? ST_RACT : ST_CSU;
         ST_CSU:  if (tmr_done) st_n = ST_CHLD;
         ST_CHLD: if (tmr_done) st_n = ST_ACC;
         ST_ACC: begin
            if (tmr_done) begin
               capture = 1'b1;
               st_n    = ST_PRE;
            end
         end
         ST_RACT: begin
            if (tmr_done) begin
               rf_adv = 1'b1;
               st_n   = ST_PRE;
            end
         end
         ST_PRE:  if (tmr_done) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   assign tmr_load = (st_n != st_q);
   assign tmr_val  = CW'(dur_of(st_n) - 1);
   assign stb_n    = decode(st_n, late_n);

   always_comb begin
      case (st_n)
         ST_RSU, ST_RHLD, ST_RACT: asel_n = AS_ROW;
         ST_CSU, ST_CHLD, ST_ACC:  asel_n = AS_COL;
         default:                  asel_n = AS_NONE;
      endcase
   end

   dram_seq_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   dram_seq_rfsh #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_rfsh (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rfsh_req),
      .take  (rf_take),
      .adv   (rf_adv),
      .pend  (rf_pend),
      .row   (rf_row)
   );

   dram_seq_amux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
      .sel  (asel_n),
      .row  (row_n),
      .col  (col_n),
      .pins (pins_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rf_q       <= 1'b0;
         late_q     <= 1'b0;
         row_q      <= '0;
         col_q      <= '0;
         dram_ras_n <= 1'b1;
         dram_cas_n <= 1'b1;
         dram_oe_n  <= 1'b1;
         dram_a     <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         st_q       <= st_n;
         rf_q       <= rf_n;
         late_q     <= late_n;
         row_q      <= row_n;
         col_q      <= col_n;
         dram_ras_n <= stb_n.ras_n;
         dram_cas_n <= stb_n.cas_n;
         dram_oe_n  <= stb_n.oe_n;
         dram_a     <= pins_n;
         rd_valid   <= capture;
         if (capture) rd_data <= dram_dq;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign dram_we_n = 1'b1;

   AST_ROW_SETUP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $stable(dram_a)); // R3
   AST_COL_SETUP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> $stable(dram_a)); // R4
   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n); // R4
   AST_EARLY_OE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!late_q && $fell(dram_cas_n)) |-> !dram_oe_n); // R5
   AST_LATE_OE_UNDER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (late_q && !dram_oe_n) |-> !dram_cas_n); // R6
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R7
   AST_VALID_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (dram_ras_n && dram_cas_n && dram_oe_n)); // R7
   AST_RFSH_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_q && !dram_ras_n) |-> (dram_cas_n && dram_oe_n)); // R8
   AST_RAS_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> busy); // R9

endmodule

// File: tb/tb_dram_read_seq.sv
`timescale 1ns/1ps
module tb_dram_read_seq;

   localparam int ROW_W = 9, COL_W = 9, DATA_W = 8;
   localparam int AW = ROW_W + COL_W;
   localparam int T_RSU = 2, T_RH = 1, T_CSU = 1, T_CH = 2, T_ACC = 3, T_PRE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req = 1'b0, late_mode = 1'b0, rfsh_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic busy, rd_valid, dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n;
   logic [DATA_W-1:0] rd_data, dram_dq;
   logic [ROW_W-1:0] dram_a;

   always #2 clk = ~clk;

   dram_read_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .T_RSU(T_RSU), .T_RH(T_RH), .T_CSU(T_CSU), .T_CH(T_CH),
      .T_ACC(T_ACC), .T_PRE(T_PRE)) dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .late_mode(late_mode), .rfsh_req(rfsh_req), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_a(dram_a),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
      .dram_we_n(dram_we_n), .dram_dq(dram_dq));

   int tests = 0, fails = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] memf(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
      return r[7:0] ^ {c[3:0], c[7:4]} ^ {r[8], 6'b0, c[8]} ^ 8'h3C;
   endfunction

   // memory model and expectations
   logic [ROW_W-1:0] m_row = '0, exp_row = '0, exp_rrow = '0;
   logic [COL_W-1:0] m_col = '0, exp_col = '0;
   logic exp_rf = 0, exp_late = 0;
   assign dram_dq = (!dram_cas_n && !dram_oe_n) ? memf(m_row, m_col) : '0;

   int n = 0, run_a = 0, ras_fall_n = 0, cas_fall_n = 0, oe_fall_n = 0, ras_rise_n = 0;
   bit have_rise = 0, row_held = 0, cyc_rf = 0, cyc_cas = 0, cyc_oe = 0;
   logic p_ras = 1, p_cas = 1, p_oe = 1, p_busy = 0;
   logic [ROW_W-1:0] p_a = '0;
   int valid_cnt = 0, rf_done = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         n++;
         if (dram_a == p_a) run_a++; else run_a = 1;
         if (p_ras && !dram_ras_n) begin
            ras_fall_n = n; row_held = 0; cyc_cas = 0; cyc_oe = 0;
            cyc_rf = exp_rf; m_row = dram_a;
            chk(run_a - 1 >= T_RSU, "R3 row setup", run_a - 1, T_RSU);
            if (exp_rf) chk(dram_a == exp_rrow, "R8 refresh row", dram_a, exp_rrow);
            else        chk(dram_a == exp_row, "R2 row", dram_a, exp_row);
            if (have_rise) chk(n - ras_rise_n >= T_PRE, "R9 ras high", n - ras_rise_n, T_PRE);
         end
         if (!dram_ras_n && !row_held && dram_a != m_row) begin
            row_held = 1;
            chk(n - ras_fall_n == T_RH, "R3 row hold", n - ras_fall_n, T_RH);
         end
         if (p_cas && !dram_cas_n) begin
            cyc_cas = 1; cas_fall_n = n; m_col = dram_a;
            chk(dram_a == exp_col, "R2 col", dram_a, exp_col);
            chk(run_a - 1 >= T_CSU, "R4 col setup", run_a - 1, T_CSU);
            chk(dram_oe_n == exp_late, exp_late ? "R6 oe at cas" : "R5 oe at cas",
                dram_oe_n, exp_late);
         end
         if (p_oe && !dram_oe_n) begin
            cyc_oe = 1; oe_fall_n = n;
            if (exp_late) chk(n - cas_fall_n == T_CH, "R6 late oe", n - cas_fall_n, T_CH);
         end
         if (rd_valid) begin
            int want;
            valid_cnt++;
            want = exp_late ? oe_fall_n + T_ACC : cas_fall_n + T_CH + T_ACC;
            chk(rd_data == memf(m_row, m_col), "R7 data", rd_data, memf(m_row, m_col));
            chk(n == want, "R7 valid timing", n, want);
            chk(dram_ras_n && dram_cas_n && dram_oe_n, "R7 strobes off",
                {dram_ras_n, dram_cas_n, dram_oe_n}, 3'b111);
         end
         if (!p_ras && dram_ras_n) begin
            ras_rise_n = n; have_rise = 1;
            chk(dram_we_n == 1'b1, "R13 we_n", dram_we_n, 1);
            if (cyc_rf) begin
               chk(!cyc_cas && !cyc_oe, "R8 row only", {cyc_cas, cyc_oe}, 0);
               chk(n - ras_fall_n == T_RH + T_ACC, "R8 ras width", n - ras_fall_n, T_RH + T_ACC);
               rf_done++;
               exp_rrow = exp_rrow + 1'b1;
            end
         end
         if (p_busy && !busy)
            chk(n - ras_rise_n == T_PRE, "R9 busy fall", n - ras_rise_n, T_PRE);
         p_ras = dram_ras_n; p_cas = dram_cas_n; p_oe = dram_oe_n; p_a = dram_a; p_busy = busy;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic do_read(input logic [AW-1:0] ad, input logic lt, input bit intrude);
      int v0;
      wait_idle();
      v0 = valid_cnt;
      exp_rf = 0; exp_row = ad[AW-1:COL_W]; exp_col = ad[COL_W-1:0]; exp_late = lt;
      rd_addr = ad; late_mode = lt; rd_req = 1;
      @(negedge clk);
      rd_req = 0; late_mode = 1'($urandom); rd_addr = AW'($urandom);
      chk(busy == 1'b1, "R9 busy rise", busy, 1);
      if (intrude) begin
         repeat (3) @(negedge clk);
         rd_req = 1;
         @(negedge clk);
         rd_req = 0;
      end
      while (busy) @(negedge clk);
      chk(valid_cnt == v0 + 1, "R7 one valid", valid_cnt - v0, 1);
      if (intrude) begin
         repeat (20) @(negedge clk);
         chk(valid_cnt == v0 + 1 && !busy, "R12 ignored", valid_cnt - v0, 1);
      end
   endtask

   task automatic do_refresh();
      int r0;
      wait_idle();
      r0 = rf_done;
      exp_rf = 1;
      rfsh_req = 1;
      @(negedge clk);
      rfsh_req = 0;
      while (busy) @(negedge clk);
      chk(rf_done == r0 + 1, "R8 refresh done", rf_done - r0, 1);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n, "R1 strobes",
          {dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}, 4'hF);
      chk(!busy && !rd_valid, "R1 idle", {busy, rd_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && dram_ras_n, "R1 after release", {busy, dram_ras_n}, 1);

      do_read('0, 0, 0);
      do_read('1, 1, 0);
      do_read(18'h2A5A5, 0, 0);
      do_read(18'h15A5A, 1, 0);
      do_refresh();
      do_read(18'h3C0F3, 1, 1);
      do_read(18'h00F0F, 0, 1);

      // R10: simultaneous refresh and read
      begin
         int v0, r0;
         wait_idle();
         v0 = valid_cnt; r0 = rf_done;
         exp_rf = 1; rd_addr = 18'h12345; late_mode = 0;
         rd_req = 1; rfsh_req = 1;
         @(negedge clk);
         rd_req = 0; rfsh_req = 0;
         while (busy) @(negedge clk);
         repeat (20) @(negedge clk);
         chk(rf_done == r0 + 1, "R10 refresh won", rf_done - r0, 1);
         chk(valid_cnt == v0 && !busy, "R10 read dropped", valid_cnt - v0, 0);
      end

      // R11: refresh raised during a read
      for (int k = 0; k < 2; k++) begin
         int v0, r0, guard;
         logic [AW-1:0] ad;
         wait_idle();
         ad = AW'($urandom);
         v0 = valid_cnt; r0 = rf_done;
         exp_rf = 0; exp_row = ad[AW-1:COL_W]; exp_col = ad[COL_W-1:0]; exp_late = 1'(k);
         rd_addr = ad; late_mode = 1'(k); rd_req = 1;
         @(negedge clk);
         rd_req = 0;
         while (dram_cas_n) @(negedge clk);
         rfsh_req = 1;
         @(negedge clk);
         rfsh_req = 0;
         while (!rd_valid) @(negedge clk);
         exp_rf = 1;
         guard = 0;
         while (rf_done == r0 && guard < 100) begin @(negedge clk); guard++; end
         wait_idle();
         chk(rf_done == r0 + 1, "R11 refresh followed", rf_done - r0, 1);
         chk(valid_cnt == v0 + 1, "R11 read intact", valid_cnt - v0, 1);
      end

      // random reads mixed with refreshes
      for (int i = 0; i < 80; i++) begin
         if ($urandom % 5 == 0) do_refresh();
         else do_read(AW'($urandom), 1'($urandom), ($urandom % 8) == 0);
      end

      // R8: walk the refresh counter across its wrap
      for (int i = 0; i < 520; i++) do_refresh();
      do_read(18'h3FFFF, 0, 0);

      wait_idle();
      if (!done_flag) begin
         done_flag = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done_flag) begin
         done_flag = 1;
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule